// File: doc/BRIEF.md
# Clock Output Run/Stop/Tristate Gating

This block sits between a clock synthesizer's internal source clocks and its output pads. It decides, for every output, whether the clock runs, is parked, or floats. The outputs are:

- differential CPU pairs, each with a true leg and a complement leg
- memory-link clocks
- graphics-port clocks
- stoppable PCI clocks and free-running PCI clocks
- reference clocks
- two utility clocks: the USB-rate clock and the super-I/O-rate clock

Each output has a register enable bit. Three active-low stop pins act on top of the enables:

- the CPU stop pin halts every CPU pair;
- the PCI stop pin halts every PCI output except the free-running ones;
- the general clock stop pin always halts the memory-link clocks, and halts a CPU pair or a graphics clock only where that output's permission bit is set.

Each output group has its own source clock domain. Inside that domain the block synchronizes the stop pins and its own reset release. The run decision is taken only on a falling edge of the group clock, so no output ever shows a shortened pulse. Per-group inversion bits flip the phase of the CPU, memory-link, graphics and PCI clocks. A further bit puts the USB-rate clock 180 degrees out of phase with the super-I/O-rate clock. A global bit floats every output at once.

Top module: `clk_out_gate`

## Requirements
- R1: An output whose enable bit is 1 runs and one whose enable bit is 0 is held low. A change of enable is taken up at the next falling edge of that group's clock, so the change first shows in the following high phase.
- R2: With pci_stop_n low, every stoppable PCI output is held low, while the free-running PCI outputs (pcif_o) keep running.
- R3: With cpu_stop_n low, every CPU pair stops whatever its permission bit holds. No other group is affected.
- R4: With clk_stop_n low:
  - the memory-link clocks always stop;
  - CPU pair i stops only if perm_cpu[i] is 1;
  - graphics clock i stops only if perm_agp[i] is 1.
- R5: A stopped CPU pair floats its complement leg (cpu_c_oe bit 0). Its true leg is driven high when cpu_t_drive is 1 and floats when cpu_t_drive is 0. A running pair drives both legs, with the complement as the inverse of the true leg.
- R6: tri_all = 1 clears every output enable (cpu_t_oe, cpu_c_oe, se_oe) at once, without waiting for a clock edge. With tri_all = 0, se_oe is 1.
- R7: With its inversion bit set, a running group's outputs follow the inverted source clock. With inv_usb = 1 and equal sources, usb_o is the inverse of sio_o.
- R8: A stop pin is sampled by a two-stage synchronizer on rising edges of the group clock. A change made just after a rising edge takes effect at the falling edge that follows the second rising edge. The output keeps its old behaviour through both high phases before that falling edge. Release follows the same timing.
- R9: While rst_n is low, every output is parked. Clock outputs are low, cpu_c_oe is 0, and a driven true leg sits high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized per group |
| cpu_src | input | 1 | CPU group source clock |
| zclk_src | input | 1 | Memory-link group source clock |
| agp_src | input | 1 | Graphics group source clock |
| pci_src | input | 1 | PCI group source clock |
| ref_src | input | 1 | Reference group source clock |
| usb_src | input | 1 | USB-rate source clock |
| sio_src | input | 1 | Super-I/O-rate source clock |
| cpu_stop_n | input | 1 | Active-low stop for all CPU pairs |
| pci_stop_n | input | 1 | Active-low stop for the stoppable PCI outputs |
| clk_stop_n | input | 1 | Active-low general clock stop |
| en_cpu | input | N_CPU | Enable per CPU pair |
| en_zclk | input | N_ZCLK | Enable per memory-link clock |
| en_agp | input | N_AGP | Enable per graphics clock |
| en_pci | input | N_PCI | Enable per stoppable PCI clock |
| en_pcif | input | N_PCIF | Enable per free-running PCI clock |
| en_ref | input | N_REF | Enable per reference clock |
| en_usb | input | 1 | Enable of the USB-rate clock |
| en_sio | input | 1 | Enable of the super-I/O-rate clock |
| perm_cpu | input | N_CPU | Lets clk_stop_n stop each CPU pair |
| perm_agp | input | N_AGP | Lets clk_stop_n stop each graphics clock |
| cpu_t_drive | input | 1 | Drive stopped true legs high (1) or float them (0) |
| tri_all | input | 1 | Float every output |
| inv_cpu | input | 1 | Invert CPU group phase |
| inv_zclk | input | 1 | Invert memory-link group phase |
| inv_agp | input | 1 | Invert graphics group phase |
| inv_pci | input | 1 | Invert PCI group phase, free-running outputs included |
| inv_usb | input | 1 | Put USB-rate clock in antiphase to the super-I/O-rate clock |
| cpu_t | output | N_CPU | CPU true legs |
| cpu_c | output | N_CPU | CPU complement legs |
| cpu_t_oe | output | N_CPU | Output enable of CPU true legs |
| cpu_c_oe | output | N_CPU | Output enable of CPU complement legs |
| zclk_o | output | N_ZCLK | Memory-link clocks |
| agp_o | output | N_AGP | Graphics clocks |
| pci_o | output | N_PCI | Stoppable PCI clocks |
| pcif_o | output | N_PCIF | Free-running PCI clocks |
| ref_o | output | N_REF | Reference clocks |
| usb_o | output | 1 | USB-rate clock |
| sio_o | output | 1 | Super-I/O-rate clock |
| se_oe | output | 1 | Output enable of all single-ended outputs |

## Verification
The block's results fall due at three different times, and each check is placed to match.

- **tri_all:** it acts through logic only, so its checks are made right after the stimulus with no edge in between.
- **Enable bits:** these are captured on a falling edge of the group clock. The bench drives them 1 ns after a rising edge and expects the new state in the next high phase.
- **Stop pins:** these pass two rising-edge flops and then the falling-edge capture. Changed 1 ns after a rising edge, a pin leaves the first two following high phases unchanged and takes effect in the third; the bench samples each of these three phases.

Every other scenario waits five cycles before it checks. It then samples 1 ns after a rising edge and 1 ns after a falling edge, so both the level and the phase of each clock are seen.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;
  // Index of each stop pin inside the CPU group's stop vector
  localparam int PIN_CPU_STOP = 0;
  localparam int PIN_CLK_STOP = 1;
  localparam int CPU_STOP_PINS = 2;
endpackage

// File: rtl/clkgate_group.sv
`timescale 1ns/1ps
// One clock domain: reset-release sync, stop-pin sync, and a falling-edge
// run register per output. stop_mask[k][i] lets stop pin k halt output i.
module clkgate_group #(
  parameter int N     = 2,
  parameter int NSTOP = 1
) (
  input  logic                      src,
  input  logic                      inv,
  input  logic                      arst_n,
  input  logic [NSTOP-1:0]          stop_n,
  input  logic [NSTOP-1:0][N-1:0]   stop_mask,
  input  logic [N-1:0]              en,
  output logic [N-1:0]              run_q
);
  logic g;
  assign g = src ^ inv;

  // reset release, synchronized to the group clock
  logic [1:0] rst_sh, rst_sh_nx;
  logic       rst_q;
  always_comb rst_sh_nx = {rst_sh[0], 1'b1};
  always_ff @(posedge g or negedge arst_n) begin
    if (!arst_n) rst_sh <= '0;
    else         rst_sh <= rst_sh_nx;
  end
  assign rst_q = rst_sh[1];

  // two-stage synchronizer for the active-low stop pins
  logic [NSTOP-1:0] s1, s2, s1_nx;
  always_comb s1_nx = ~stop_n;
  always_ff @(posedge g or negedge rst_q) begin
    if (!rst_q) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= s1_nx;
      s2 <= s1;
    end
  end

  // run decision
  logic [N-1:0] hit, run_req;
  always_comb begin
    hit = '0;
    for (int k = 0; k < NSTOP; k++) hit = hit | ({N{s2[k]}} & stop_mask[k]);
    run_req = en & ~hit;
  end

  // captured while g is low: the gated clock changes only in its low phase
  always_ff @(negedge g or negedge rst_q) begin
    if (!rst_q) run_q <= '0;
    else        run_q <= run_req;
  end

  for (genvar k = 0; k < NSTOP; k++) begin : g_pin_chk
    assert_sync_rise_R8: assert property (@(posedge g) disable iff (!rst_q)
      $rose(s2[k]) |-> !$past(stop_n[k]));
    assert_sync_fall_R8: assert property (@(posedge g) disable iff (!rst_q)
      $fell(s2[k]) |-> $past(stop_n[k]));
    for (genvar i = 0; i < N; i++) begin : g_out_chk
      assert_stop_hold_R4: assert property (@(negedge g) disable iff (!rst_q)
        (s2[k] && stop_mask[k][i]) |=> !run_q[i]);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_run_chk
    assert_run_R1: assert property (@(negedge g) disable iff (!rst_q)
      (en[i] && !hit[i]) |=> run_q[i]);
  end
endmodule

// File: rtl/clk_out_gate.sv
`timescale 1ns/1ps
module clk_out_gate
  import clkgate_pkg::*;
#(
  parameter int N_CPU  = 2,
  parameter int N_ZCLK = 2,
  parameter int N_AGP  = 2,
  parameter int N_PCI  = 7,
  parameter int N_PCIF = 2,
  parameter int N_REF  = 3
) (
  input  logic              rst_n,
  input  logic              cpu_src,
  input  logic              zclk_src,
  input  logic              agp_src,
  input  logic              pci_src,
  input  logic              ref_src,
  input  logic              usb_src,
  input  logic              sio_src,
  input  logic              cpu_stop_n,
  input  logic              pci_stop_n,
  input  logic              clk_stop_n,
  input  logic [N_CPU-1:0]  en_cpu,
  input  logic [N_ZCLK-1:0] en_zclk,
  input  logic [N_AGP-1:0]  en_agp,
  input  logic [N_PCI-1:0]  en_pci,
  input  logic [N_PCIF-1:0] en_pcif,
  input  logic [N_REF-1:0]  en_ref,
  input  logic              en_usb,
  input  logic              en_sio,
  input  logic [N_CPU-1:0]  perm_cpu,
  input  logic [N_AGP-1:0]  perm_agp,
  input  logic              cpu_t_drive,
  input  logic              tri_all,
  input  logic              inv_cpu,
  input  logic              inv_zclk,
  input  logic              inv_agp,
  input  logic              inv_pci,
  input  logic              inv_usb,
  output logic [N_CPU-1:0]  cpu_t,
  output logic [N_CPU-1:0]  cpu_c,
  output logic [N_CPU-1:0]  cpu_t_oe,
  output logic [N_CPU-1:0]  cpu_c_oe,
  output logic [N_ZCLK-1:0] zclk_o,
  output logic [N_AGP-1:0]  agp_o,
  output logic [N_PCI-1:0]  pci_o,
  output logic [N_PCIF-1:0] pcif_o,
  output logic [N_REF-1:0]  ref_o,
  output logic              usb_o,
  output logic              sio_o,
  output logic              se_oe
);
  localparam int N_PCI_ALL = N_PCI + N_PCIF;

  // group clocks after phase selection
  logic cpu_g, zclk_g, agp_g, pci_g, usb_g;
  assign cpu_g  = cpu_src  ^ inv_cpu;
  assign zclk_g = zclk_src ^ inv_zclk;
  assign agp_g  = agp_src  ^ inv_agp;
  assign pci_g  = pci_src  ^ inv_pci;
  assign usb_g  = usb_src  ^ inv_usb;

  // CPU: own stop pin over all pairs, general stop under permission
  logic [CPU_STOP_PINS-1:0][N_CPU-1:0] cpu_mask;
  logic [CPU_STOP_PINS-1:0]            cpu_pins;
  logic [N_CPU-1:0]                    cpu_run;
  always_comb begin
    cpu_mask[PIN_CPU_STOP] = '1;
    cpu_mask[PIN_CLK_STOP] = perm_cpu;
    cpu_pins[PIN_CPU_STOP] = cpu_stop_n;
    cpu_pins[PIN_CLK_STOP] = clk_stop_n;
  end
  clkgate_group #(.N(N_CPU), .NSTOP(CPU_STOP_PINS)) u_cpu (
    .src(cpu_src), .inv(inv_cpu), .arst_n(rst_n), .stop_n(cpu_pins),
    .stop_mask(cpu_mask), .en(en_cpu), .run_q(cpu_run));

  logic [N_ZCLK-1:0] zclk_run;
  clkgate_group #(.N(N_ZCLK), .NSTOP(1)) u_zclk (
    .src(zclk_src), .inv(inv_zclk), .arst_n(rst_n), .stop_n(clk_stop_n),
    .stop_mask({N_ZCLK{1'b1}}), .en(en_zclk), .run_q(zclk_run));

  logic [N_AGP-1:0] agp_run;
  clkgate_group #(.N(N_AGP), .NSTOP(1)) u_agp (
    .src(agp_src), .inv(inv_agp), .arst_n(rst_n), .stop_n(clk_stop_n),
    .stop_mask(perm_agp), .en(en_agp), .run_q(agp_run));

  // PCI: free-running outputs sit in the upper bits with a zero mask
  logic [N_PCI_ALL-1:0] pci_run;
  clkgate_group #(.N(N_PCI_ALL), .NSTOP(1)) u_pci (
    .src(pci_src), .inv(inv_pci), .arst_n(rst_n), .stop_n(pci_stop_n),
    .stop_mask({{N_PCIF{1'b0}}, {N_PCI{1'b1}}}),
    .en({en_pcif, en_pci}), .run_q(pci_run));

  logic [N_REF-1:0] ref_run;
  clkgate_group #(.N(N_REF), .NSTOP(1)) u_ref (
    .src(ref_src), .inv(1'b0), .arst_n(rst_n), .stop_n(1'b1),
    .stop_mask({N_REF{1'b0}}), .en(en_ref), .run_q(ref_run));

  logic usb_run, sio_run;
  clkgate_group #(.N(1), .NSTOP(1)) u_usb (
    .src(usb_src), .inv(inv_usb), .arst_n(rst_n), .stop_n(1'b1),
    .stop_mask(1'b0), .en(en_usb), .run_q(usb_run));
  clkgate_group #(.N(1), .NSTOP(1)) u_sio (
    .src(sio_src), .inv(1'b0), .arst_n(rst_n), .stop_n(1'b1),
    .stop_mask(1'b0), .en(en_sio), .run_q(sio_run));

  // output stage
  always_comb begin
    cpu_t    = ({N_CPU{cpu_g}} & cpu_run) | ~cpu_run;
    cpu_c    = ~{N_CPU{cpu_g}} & cpu_run;
    cpu_t_oe = {N_CPU{~tri_all}} & (cpu_run | {N_CPU{cpu_t_drive}});
    cpu_c_oe = {N_CPU{~tri_all}} & cpu_run;
    zclk_o   = {N_ZCLK{zclk_g}} & zclk_run;
    agp_o    = {N_AGP{agp_g}} & agp_run;
    pci_o    = {N_PCI{pci_g}} & pci_run[N_PCI-1:0];
    pcif_o   = {N_PCIF{pci_g}} & pci_run[N_PCI_ALL-1:N_PCI];
    ref_o    = {N_REF{ref_src}} & ref_run;
    usb_o    = usb_g & usb_run;
    sio_o    = sio_src & sio_run;
    se_oe    = ~tri_all;
  end

  assert_tristate_R6: assert property (@(posedge cpu_src) disable iff (!rst_n)
    tri_all |-> (cpu_t_oe == '0 && cpu_c_oe == '0 && !se_oe));
  assert_legs_R5: assert property (@(posedge cpu_src) disable iff (!rst_n)
    (!tri_all && !cpu_t_drive) |-> (cpu_t_oe == cpu_c_oe));
endmodule

// File: tb/clk_out_gate_test.sv
`timescale 1ns/100ps
module clk_out_gate_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic cpu_stop_n, pci_stop_n, clk_stop_n;
  logic [1:0] en_cpu, en_zclk, en_agp, en_pcif, perm_cpu, perm_agp;
  logic [6:0] en_pci;
  logic [2:0] en_ref;
  logic en_usb, en_sio, cpu_t_drive, tri_all;
  logic inv_cpu, inv_zclk, inv_agp, inv_pci, inv_usb;
  logic [1:0] cpu_t, cpu_c, cpu_t_oe, cpu_c_oe, zclk_o, agp_o, pcif_o;
  logic [6:0] pci_o;
  logic [2:0] ref_o;
  logic usb_o, sio_o, se_oe;

  clk_out_gate uut (
    .rst_n(rst_n), .cpu_src(clk), .zclk_src(clk), .agp_src(clk), .pci_src(clk),
    .ref_src(clk), .usb_src(clk), .sio_src(clk),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .clk_stop_n(clk_stop_n),
    .en_cpu(en_cpu), .en_zclk(en_zclk), .en_agp(en_agp), .en_pci(en_pci),
    .en_pcif(en_pcif), .en_ref(en_ref), .en_usb(en_usb), .en_sio(en_sio),
    .perm_cpu(perm_cpu), .perm_agp(perm_agp), .cpu_t_drive(cpu_t_drive),
    .tri_all(tri_all), .inv_cpu(inv_cpu), .inv_zclk(inv_zclk), .inv_agp(inv_agp),
    .inv_pci(inv_pci), .inv_usb(inv_usb),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_t_oe(cpu_t_oe), .cpu_c_oe(cpu_c_oe),
    .zclk_o(zclk_o), .agp_o(agp_o), .pci_o(pci_o), .pcif_o(pcif_o),
    .ref_o(ref_o), .usb_o(usb_o), .sio_o(sio_o), .se_oe(se_oe));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_edge; @(posedge clk); #1; endtask
  task automatic at_hi; @(posedge clk); #1; endtask
  task automatic at_lo; @(negedge clk); #1; endtask
  task automatic settle; repeat (5) @(posedge clk); endtask

  task automatic set_defaults;
    cpu_stop_n = 1; pci_stop_n = 1; clk_stop_n = 1;
    en_cpu = '1; en_zclk = '1; en_agp = '1; en_pci = '1; en_pcif = '1;
    en_ref = '1; en_usb = 1; en_sio = 1; perm_cpu = '1; perm_agp = '1;
    cpu_t_drive = 0; tri_all = 0;
    inv_cpu = 0; inv_zclk = 0; inv_agp = 0; inv_pci = 0; inv_usb = 0;
  endtask

  task automatic t_reset;
    cpu_t_drive = 1;
    repeat (3) @(posedge clk);
    at_hi;
    chk("R9 pci low in reset", pci_o, 7'h00);
    chk("R9 zclk low in reset", zclk_o, 2'b00);
    chk("R9 cpu true parked high", cpu_t, 2'b11);
    chk("R9 cpu true oe driven", cpu_t_oe, 2'b11);
    chk("R9 cpu comp floats", cpu_c_oe, 2'b00);
    chk("R6 se_oe with tri_all=0", se_oe, 1'b1);
    cpu_t_drive = 0;
  endtask

  task automatic t_enables;
    drive_edge; set_defaults; settle;
    at_hi;
    chk("R1 pci hi", pci_o, 7'h7F); chk("R1 pcif hi", pcif_o, 2'b11);
    chk("R1 zclk hi", zclk_o, 2'b11); chk("R1 agp hi", agp_o, 2'b11);
    chk("R1 ref hi", ref_o, 3'b111); chk("R1 cpu_t hi", cpu_t, 2'b11);
    chk("R1 cpu_c hi", cpu_c, 2'b00);
    at_lo;
    chk("R1 pci lo", pci_o, 7'h00); chk("R1 cpu_c lo", cpu_c, 2'b11);
    drive_edge;
    en_pci = 7'h55; en_ref = 3'b010; en_zclk = 2'b10; en_agp = 2'b01;
    en_pcif = 2'b10; en_sio = 0;
    settle; at_hi;
    chk("R1 pci pattern", pci_o, 7'h55); chk("R1 ref pattern", ref_o, 3'b010);
    chk("R1 zclk pattern", zclk_o, 2'b10); chk("R1 agp pattern", agp_o, 2'b01);
    chk("R1 pcif pattern", pcif_o, 2'b10); chk("R1 sio disabled", sio_o, 1'b0);
    at_lo;
    chk("R1 disabled held low", {pci_o, ref_o}, 10'h000);
    drive_edge; en_pci = 7'h2A;
    at_hi;
    chk("R1 enable taken at next fall", pci_o, 7'h2A);
  endtask

  task automatic t_pci_stop;
    drive_edge; set_defaults; settle;
    drive_edge; pci_stop_n = 0;
    at_hi; chk("R8 pci runs 1st high", pci_o, 7'h7F);
    at_hi; chk("R8 pci runs 2nd high", pci_o, 7'h7F);
    at_hi; chk("R2 pci stopped", pci_o, 7'h00);
    chk("R2 pcif free running", pcif_o, 2'b11);
    chk("R2 zclk unaffected", zclk_o, 2'b11);
    at_lo; chk("R2 pci held low", pci_o, 7'h00);
    drive_edge; pci_stop_n = 1;
    at_hi; chk("R8 pci held 1st high", pci_o, 7'h00);
    at_hi; chk("R8 pci held 2nd high", pci_o, 7'h00);
    at_hi; chk("R8 pci restarted", pci_o, 7'h7F);
  endtask

  task automatic t_cpu_stop;
    drive_edge; set_defaults; perm_cpu = 2'b00; cpu_stop_n = 0; settle;
    at_hi;
    chk("R3 cpu true oe off", cpu_t_oe, 2'b00);
    chk("R3 cpu comp oe off", cpu_c_oe, 2'b00);
    chk("R3 zclk unaffected", zclk_o, 2'b11);
  endtask

  task automatic t_clk_stop;
    drive_edge; set_defaults; perm_cpu = 2'b01; perm_agp = 2'b10; clk_stop_n = 0;
    settle; at_hi;
    chk("R4 cpu pair1 runs", cpu_c_oe, 2'b10);
    chk("R4 zclk stopped", zclk_o, 2'b00);
    chk("R4 agp perm", agp_o, 2'b01);
    chk("R4 pci unaffected", pci_o, 7'h7F);
    at_lo;
    chk("R4 cpu true legs low phase", cpu_t, 2'b01);
  endtask

  task automatic t_cpu_legs;
    drive_edge; set_defaults; cpu_stop_n = 0; cpu_t_drive = 1; settle;
    at_hi; chk("R5 true parked high hi", cpu_t, 2'b11);
    chk("R5 true oe driven", cpu_t_oe, 2'b11);
    chk("R5 comp floats", cpu_c_oe, 2'b00);
    at_lo; chk("R5 true parked high lo", cpu_t, 2'b11);
    drive_edge; cpu_t_drive = 0; #0.1;
    chk("R5 true floats without drive", cpu_t_oe, 2'b00);
    drive_edge; cpu_stop_n = 1; settle;
    at_lo; chk("R5 running comp lo", cpu_c, 2'b11);
    chk("R5 running comp oe", cpu_c_oe, 2'b11);
    at_hi; chk("R5 running comp hi", cpu_c, 2'b00);
  endtask

  task automatic t_tristate;
    drive_edge; set_defaults; cpu_t_drive = 1; settle;
    drive_edge; tri_all = 1; #0.1;
    chk("R6 se_oe off", se_oe, 1'b0);
    chk("R6 cpu true oe off", cpu_t_oe, 2'b00);
    chk("R6 cpu comp oe off", cpu_c_oe, 2'b00);
    tri_all = 0; #0.1;
    chk("R6 se_oe back", se_oe, 1'b1);
  endtask

  task automatic t_invert;
    drive_edge; set_defaults;
    inv_cpu = 1; inv_zclk = 1; inv_agp = 1; inv_pci = 1; inv_usb = 1;
    settle; at_hi;
    chk("R7 pci inverted hi", pci_o, 7'h00); chk("R7 zclk inverted hi", zclk_o, 2'b00);
    chk("R7 agp inverted hi", agp_o, 2'b00); chk("R7 usb vs sio hi", {usb_o, sio_o}, 2'b01);
    at_lo;
    chk("R7 pci inverted lo", pci_o, 7'h7F); chk("R7 pcif inverted lo", pcif_o, 2'b11);
    chk("R7 agp inverted lo", agp_o, 2'b11); chk("R7 usb vs sio lo", {usb_o, sio_o}, 2'b10);
    chk("R7 cpu true inverted lo", cpu_t, 2'b11);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rst_n = 0;
    set_defaults;
    t_reset;
    drive_edge; rst_n = 1;
    settle;
    t_enables;
    t_pci_stop;
    t_cpu_stop;
    t_clk_stop;
    t_cpu_legs;
    t_tristate;
    t_invert;
    finish_run;
  end

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run;
  end
endmodule